// File: doc/BRIEF.md
# Shared Receive Packet Queue with Per-Packet Status

This block is the one receive queue that every host channel writes into, periodic and non-periodic alike. The packet engine writes the payload of a received packet one 32-bit word at a time. After the last word it commits a status record that names the destination channel, the byte count, the data PID and a validity code. Packets are laid down one after another in a word ring, in the order they arrive, with no gap between them. The ring starts at word address 0, and its depth comes from the upper half-word (bits [31:16]) of the region size register, which this block receives as `region_depth`.

The write side cannot be stalled, because the USB line cannot wait, so it has plain strobes and no ready. If a word arrives when the region is full, the rest of that packet is thrown away. At commit the whole partial packet is rolled back and `rx_overflow` pulses. The read side has two valid/ready streams. A status record is offered first. Once it is taken, exactly ceil(bytecount/4) payload words are offered, and after them the next record. A consumer may hold either ready low for as long as it likes: while it does, valid and data stay unchanged, and a transfer happens only in a cycle where valid and ready are both high. `region_depth` may only be changed while the queue is empty.

Top module: `rx_shared_pkt_fifo`

## Requirements
- R1: After reset `st_valid`, `dt_valid`, `rx_nonempty` and `rx_overflow` are all 0.
- R2: `st_data` returns the committed record bit for bit. Its layout is channel [3:0], byte count [14:4], data PID [16:15] (DATA0=0, DATA2=1, DATA1=2, MDATA=3) and validity code [20:17].
- R3: Once a record has been taken, `dt_valid` is high for exactly ceil(bytecount/4) transfers, which return the words in the order they were pushed. Then `dt_valid` goes low. A record with a byte count of 0 is followed by no data words.
- R4: Packets from any mix of channels come out in commit order.
- R5: Words pushed without a commit are not visible: `st_valid` and `rx_nonempty` stay low until the commit edge.
- R6: If a push finds the region full, the packet is discarded at its commit and `rx_overflow` is high for the one cycle after the commit edge. Its words are reclaimed, so a later packet can use them. A packet that commits cleanly leaves `rx_overflow` low.
- R7: A commit that arrives while the record queue holds SDEPTH records is discarded in the same way and flagged on `rx_overflow`.
- R8: The effective depth in words is `region_depth`, or DEPTH when `region_depth` is 0 or larger than DEPTH. A packet of exactly the effective depth fits, and one word more overflows.
- R9: While `st_ready` or `dt_ready` is low, the matching valid and data hold steady.
- R10: `rx_nonempty` is high exactly while at least one committed record has not yet been taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| region_depth | input | 16 | Region depth in words (size register bits [31:16]) |
| wr_push | input | 1 | Payload word strobe |
| wr_data | input | 32 | Payload word |
| wr_commit | input | 1 | Commit the status record; may share a cycle with the last push |
| wr_status | input | 21 | Status record to commit |
| rx_overflow | output | 1 | One-cycle pulse after a discarded commit |
| st_valid | output | 1 | Status record offered |
| st_ready | input | 1 | Consumer takes the status record |
| st_data | output | 21 | Oldest status record |
| dt_valid | output | 1 | Payload word offered |
| dt_ready | input | 1 | Consumer takes the payload word |
| dt_data | output | 32 | Payload word |
| rx_nonempty | output | 1 | At least one committed record pending |

## Verification
A bad word count or a bad ring pointer shows up at the ports as soon as the next packet is read. The payload shifts by a word, or `dt_valid` stays high past the end of the packet, or `st_valid` appears while a packet is still being read. A wrong space count or a missed rollback shows on the first commit near the region limit. There `rx_overflow` disagrees with the expected outcome in the cycle after the commit, and the payload of later packets no longer lines up. The bench keeps its own queue of committed packets and its own occupancy count. It predicts each discard from those, so every divergence is caught at the packet where it first happens.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int STS_W = 21;

  typedef enum logic [1:0] {
    PID_DATA0 = 2'd0,
    PID_DATA2 = 2'd1,
    PID_DATA1 = 2'd2,
    PID_MDATA = 2'd3
  } pid_e;

  typedef struct packed {
    logic [3:0]  pkt_code;
    pid_e        pid;
    logic [10:0] bytes;
    logic [3:0]  chan;
  } rx_sts_t;

  function automatic logic [9:0] words_of(input logic [10:0] b);
    logic [11:0] s;
    s = {1'b0, b} + 12'd3;
    return s[11:2];
  endfunction
endpackage

// File: rtl/rxq_word_ring.sv
module rxq_word_ring #(
  parameter int DEPTH = 64,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] eff_depth,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          commit_ok,
  input  logic          rollback,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          ovf_now
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, cptr, rptr;
  logic [CW-1:0] used_c, pend;
  logic          dropping;
  logic          push_acc;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p, input logic [CW-1:0] lim);
    return (({1'b0, p} + CW'(1)) >= lim) ? '0 : p + AW'(1);
  endfunction

  assign push_acc = push && !dropping && ((used_c + pend) < eff_depth);
  assign ovf_now  = dropping || (push && !push_acc);
  assign rdata    = mem[rptr];

  always_ff @(posedge clk) begin
    if (push_acc) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr     <= '0;
      cptr     <= '0;
      rptr     <= '0;
      used_c   <= '0;
      pend     <= '0;
      dropping <= 1'b0;
    end else begin
      if (rollback)      wptr <= cptr;
      else if (push_acc) wptr <= nxt(wptr, eff_depth);

      if (commit_ok) cptr <= push_acc ? nxt(wptr, eff_depth) : wptr;

      if (commit_ok || rollback) pend <= '0;
      else if (push_acc)         pend <= pend + CW'(1);

      used_c <= used_c
              + (commit_ok ? (pend + CW'(push_acc)) : '0)
              - CW'(pop);

      if (commit_ok || rollback)  dropping <= 1'b0;
      else if (push && !push_acc) dropping <= 1'b1;

      if (pop) rptr <= nxt(rptr, eff_depth);
    end
  end

  // R3: a word is only taken while committed words remain
  a_r3_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (used_c != '0));

  // R8: occupancy never exceeds the programmed region
  a_r8_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    (used_c + pend) <= eff_depth);
endmodule

// File: rtl/rxq_sts_queue.sv
module rxq_sts_queue #(
  parameter int SDEPTH = 8,
  parameter int W      = 21,
  localparam int SAW   = $clog2(SDEPTH),
  localparam int SCW   = SAW + 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] pdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         full,
  output logic         empty
);
  logic [W-1:0]   q [SDEPTH];
  logic [SAW-1:0] wp, rp;
  logic [SCW-1:0] cnt;

  assign full  = (cnt == SCW'(SDEPTH));
  assign empty = (cnt == '0);
  assign head  = q[rp];

  always_ff @(posedge clk) begin
    if (push) q[wp] <= pdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == SAW'(SDEPTH - 1)) ? '0 : wp + SAW'(1);
      if (pop)  rp <= (rp == SAW'(SDEPTH - 1)) ? '0 : rp + SAW'(1);
      cnt <= cnt + SCW'(push) - SCW'(pop);
    end
  end

  // R7: a record is never written into a full queue
  a_r7_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R2: a record is never taken from an empty queue
  a_r2_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/rxq_pop_seq.sv
module rxq_pop_seq
  import rxq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sts_avail,
  input  rx_sts_t head,
  input  logic    st_ready,
  input  logic    dt_ready,
  output logic    st_valid,
  output logic    st_pop,
  output logic    dt_valid,
  output logic    dt_pop
);
  logic [9:0] left;

  assign st_valid = sts_avail && (left == '0);
  assign dt_valid = (left != '0);
  assign st_pop   = st_valid && st_ready;
  assign dt_pop   = dt_valid && dt_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left <= '0;
    else if (st_pop) left <= words_of(head.bytes);
    else if (dt_pop) left <= left - 10'd1;
  end

  // R9: an offered record stays offered until it is taken
  a_r9_sts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> st_valid);

  // R9: an offered word stays offered until it is taken
  a_r9_dt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_valid && !dt_ready) |=> dt_valid);
endmodule

// File: rtl/rx_shared_pkt_fifo.sv
module rx_shared_pkt_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int SDEPTH = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      region_depth,
  input  logic             wr_push,
  input  logic [31:0]      wr_data,
  input  logic             wr_commit,
  input  logic [STS_W-1:0] wr_status,
  output logic             rx_overflow,
  output logic             st_valid,
  input  logic             st_ready,
  output logic [STS_W-1:0] st_data,
  output logic             dt_valid,
  input  logic             dt_ready,
  output logic [31:0]      dt_data,
  output logic             rx_nonempty
);
  localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

  logic [CW-1:0]    eff_depth;
  logic             ovf_now, commit_ok, rollback;
  logic             sts_full, sts_empty, st_pop, dt_pop;
  logic [STS_W-1:0] sts_head;

  assign eff_depth = ((region_depth == 16'd0) || (region_depth > 16'(DEPTH)))
                   ? DEPTH_C : region_depth[CW-1:0];

  assign commit_ok   = wr_commit && !ovf_now && !sts_full;
  assign rollback    = wr_commit && !commit_ok;
  assign st_data     = sts_head;
  assign rx_nonempty = !sts_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rx_overflow <= 1'b0;
    else        rx_overflow <= rollback;
  end

  rxq_word_ring #(.DEPTH(DEPTH), .DW(32)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .eff_depth (eff_depth),
    .push      (wr_push),
    .wdata     (wr_data),
    .commit_ok (commit_ok),
    .rollback  (rollback),
    .pop       (dt_pop),
    .rdata     (dt_data),
    .ovf_now   (ovf_now)
  );

  rxq_sts_queue #(.SDEPTH(SDEPTH), .W(STS_W)) u_sts (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (commit_ok),
    .pdata (wr_status),
    .pop   (st_pop),
    .head  (sts_head),
    .full  (sts_full),
    .empty (sts_empty)
  );

  rxq_pop_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .sts_avail (!sts_empty),
    .head      (rx_sts_t'(sts_head)),
    .st_ready  (st_ready),
    .dt_ready  (dt_ready),
    .st_valid  (st_valid),
    .st_pop    (st_pop),
    .dt_valid  (dt_valid),
    .dt_pop    (dt_pop)
  );

  // R7: a commit into a full record queue is flagged on the next cycle
  a_r7_ovf_on_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && sts_full) |=> rx_overflow);

  // R10: a record can only be offered while the pending flag is up
  a_r10_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> rx_nonempty);

  // R6: the overflow pulse only follows a commit
  a_r6_ovf_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overflow |-> $past(wr_commit));
endmodule

// File: tb/rx_shared_pkt_fifo_bench.sv
module rx_shared_pkt_fifo_bench;
  localparam int DEPTH  = 64;
  localparam int SDEPTH = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] region_depth = 16'd0;
  logic        wr_push = 1'b0, wr_commit = 1'b0;
  logic [31:0] wr_data = '0;
  logic [20:0] wr_status = '0;
  logic        rx_overflow, st_valid, dt_valid, rx_nonempty;
  logic        st_ready = 1'b0, dt_ready = 1'b0;
  logic [20:0] st_data;
  logic [31:0] dt_data;

  int n_tests = 0, n_fail = 0, eff_d = DEPTH;
  logic [20:0] m_sts[$];
  logic [31:0] m_wd[$];

  always #2 clk = ~clk;

  rx_shared_pkt_fifo #(.DEPTH(DEPTH), .SDEPTH(SDEPTH)) u_rx_shared_pkt_fifo (
    .clk(clk), .rst_n(rst_n), .region_depth(region_depth),
    .wr_push(wr_push), .wr_data(wr_data), .wr_commit(wr_commit),
    .wr_status(wr_status), .rx_overflow(rx_overflow),
    .st_valid(st_valid), .st_ready(st_ready), .st_data(st_data),
    .dt_valid(dt_valid), .dt_ready(dt_ready), .dt_data(dt_data),
    .rx_nonempty(rx_nonempty));

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: %s got %h exp %h", req, what, got, exp);
    end
  endtask

  function automatic int nwords(input int b);
    return (b + 3) / 4;
  endfunction

  function automatic logic [20:0] mk_sts(input int ch, input int b, input int pid, input int code);
    logic [20:0] s;
    s[3:0]   = 4'(ch);
    s[14:4]  = 11'(b);
    s[16:15] = 2'(pid);
    s[20:17] = 4'(code);
    return s;
  endfunction

  function automatic int eff_of(input int rd);
    return (rd == 0 || rd > DEPTH) ? DEPTH : rd;
  endfunction

  task automatic send_pkt(input int ch, input int b, input int pid, input int code,
                          input bit check_hidden, input string req);
    int nw;
    bit exp_drop;
    logic [31:0] wds[$];
    logic [20:0] s;
    nw = nwords(b);
    s = mk_sts(ch, b, pid, code);
    exp_drop = (m_wd.size() + nw > eff_d) || (m_sts.size() == SDEPTH);
    for (int i = 0; i < nw; i++) begin
      @(negedge clk);
      if (check_hidden && i == nw - 1 && i > 0) begin
        chk("R5", "st_valid before commit", 32'(st_valid), 32'd0);
        chk("R5", "rx_nonempty before commit", 32'(rx_nonempty), 32'd0);
      end
      wr_push = 1'b1;
      wr_data = $urandom;
      wds.push_back(wr_data);
      wr_commit = (i == nw - 1);
      wr_status = s;
    end
    if (nw == 0) begin
      @(negedge clk);
      wr_commit = 1'b1;
      wr_status = s;
    end
    @(negedge clk);
    wr_push = 1'b0;
    wr_commit = 1'b0;
    chk(req, "rx_overflow after commit", 32'(rx_overflow), 32'(exp_drop));
    if (!exp_drop) begin
      m_sts.push_back(s);
      foreach (wds[k]) m_wd.push_back(wds[k]);
    end
    chk("R10", "rx_nonempty after commit", 32'(rx_nonempty), 32'(m_sts.size() != 0));
  endtask

  task automatic recv_pkt(input bit bp);
    logic [20:0] es;
    logic [31:0] ew;
    int nw;
    es = m_sts.pop_front();
    nw = nwords(int'(es[14:4]));
    @(negedge clk);
    chk("R4", "st_valid", 32'(st_valid), 32'd1);
    chk("R2", "st_data", 32'(st_data), 32'(es));
    if (bp && ($urandom % 2 == 0)) begin
      @(negedge clk);
      chk("R9", "st_valid held", 32'(st_valid), 32'd1);
      chk("R9", "st_data held", 32'(st_data), 32'(es));
    end
    st_ready = 1'b1;
    @(negedge clk);
    st_ready = 1'b0;
    for (int w = 0; w < nw; w++) begin
      ew = m_wd.pop_front();
      chk("R3", "dt_valid", 32'(dt_valid), 32'd1);
      chk("R3", "dt_data", dt_data, ew);
      if (bp && ($urandom % 3 == 0)) begin
        @(negedge clk);
        chk("R9", "dt_data held", dt_data, ew);
      end
      dt_ready = 1'b1;
      @(negedge clk);
      dt_ready = 1'b0;
    end
    chk("R3", "dt_valid after last word", 32'(dt_valid), 32'd0);
    chk("R10", "rx_nonempty after read", 32'(rx_nonempty), 32'(m_sts.size() != 0));
  endtask

  task automatic drain(input bit bp);
    while (m_sts.size() != 0) recv_pkt(bp);
  endtask

  task automatic set_region(input int rd);
    @(negedge clk);
    region_depth = 16'(rd);
    eff_d = eff_of(rd);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish got %0d exp %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "st_valid", 32'(st_valid), 32'd0);
    chk("R1", "dt_valid", 32'(dt_valid), 32'd0);
    chk("R1", "rx_nonempty", 32'(rx_nonempty), 32'd0);
    chk("R1", "rx_overflow", 32'(rx_overflow), 32'd0);
    rst_n = 1'b1;
    set_region(0);

    // R5 hidden until commit, R3 zero-length packet
    send_pkt(2, 11, 2, 1, 1'b1, "R6");
    send_pkt(5, 0, 0, 3, 1'b0, "R6");
    send_pkt(9, 7, 3, 15, 1'b0, "R6");
    drain(1'b0);

    // R8 programmed depth of 16 words
    set_region(16);
    send_pkt(1, 64, 0, 1, 1'b0, "R8");
    send_pkt(1, 4, 2, 1, 1'b0, "R8");
    drain(1'b1);
    send_pkt(3, 68, 0, 1, 1'b0, "R8");
    send_pkt(4, 64, 1, 2, 1'b0, "R8");
    drain(1'b0);

    // R7 record queue full
    set_region(0);
    for (int i = 0; i < SDEPTH + 1; i++) send_pkt(i, 4, i % 4, 1, 1'b0, "R7");
    drain(1'b1);

    // R8 oversize setting clamps to DEPTH
    set_region(200);
    send_pkt(6, DEPTH * 4, 2, 1, 1'b0, "R8");
    drain(1'b0);
    send_pkt(6, DEPTH * 4 + 1, 2, 1, 1'b0, "R8");
    send_pkt(7, 1, 0, 1, 1'b0, "R6");
    drain(1'b0);

    // R4 / R6 random mix of channels and sizes
    set_region(0);
    void'($urandom(32'd1234));
    for (int it = 0; it < 400; it++) begin
      if (m_sts.size() == 0 || ($urandom % 10) < 6)
        send_pkt($urandom % 16, $urandom % 101, $urandom % 4, $urandom % 16, 1'b0, "R6");
      else
        recv_pkt(1'b1);
    end
    drain(1'b1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule